// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates addresses for a four-word burst in a synchronous memory. A burst starts when either of two address strobes is asserted. The block then captures the whole external address. The low two bits of that address become the burst's starting offset, and an internal beat count is cleared to zero.

While a burst runs, each cycle with the advance input high moves the beat count forward by one. The count wraps from three back to zero. Cycles without advance leave the address unchanged.

A static order-select input chooses how the low bits are formed from the start offset and the beat count:
- Linear order adds the beat count to the start offset, modulo four.
- Interleaved order XORs the beat count into the start offset.

The full registered address is presented with its upper bits frozen, and the current two-bit offset is presented separately.

Top module: `burst_seq`

## Requirements
- R1: While the active-low reset `rst_n` is low, `addr_out` and `offset` are zero.
- R2: A cycle with `strobe_p` or `strobe_c` high loads `addr_in`, so after that clock edge `addr_out` equals the sampled `addr_in` and `offset` equals its bits [1:0].
- R3: A strobe takes priority over `advance` and reloads even in the middle of a burst, restarting the beat count at zero.
- R4: With `interleave` low, after n advances since the last load, `offset` equals (start + n) mod 4.
- R5: With `interleave` high, after n advances since the last load, `offset` equals start XOR (n mod 4).
- R6: A cycle with no strobe and `advance` low leaves `addr_out` unchanged.
- R7: Without a strobe, `addr_out[ADDR_W-1:2]` never changes, whatever `advance` does.
- R8: Four advances after a load return `offset` to the start value in both orders.
- R9: `addr_out[1:0]` always equals `offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address, sampled when a strobe is high |
| strobe_p | input | 1 | First burst-start strobe, active high |
| strobe_c | input | 1 | Second burst-start strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Registered address with the burst offset in bits [1:0] |
| offset | output | 2 | Current burst offset |

## Verification
A corrupted beat count or start offset shows up on `offset` and `addr_out[1:0]` one clock after the advance or strobe that produced it. A bench that models the beat count independently and compares on every cycle therefore locates such a fault within one cycle.

A corrupted upper-address register, or a strobe that fails to reload, is visible in the upper bits of `addr_out` on the next cycle. The bench stresses several cases:
- mid-burst reloads;
- a strobe and advance asserted together;
- runs of more than four advances in both orders.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_p,
  input  logic              strobe_c,
  input  logic              advance,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        offset
);
  localparam int UPPER_W = ADDR_W - 2;

  logic [UPPER_W-1:0] upper_q;
  logic [1:0]         start_q;
  logic [1:0]         beat_q;
  logic               load;

  assign load = strobe_p | strobe_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      upper_q <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      beat_q  <= '0;
    end else if (advance) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign offset   = interleave ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {upper_q, offset};

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_p || strobe_c) |=> addr_out == $past(addr_in));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_c && advance) |=> offset == $past(addr_in[1:0]));

  p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p && !strobe_c && advance && !interleave)
      |=> (interleave || offset == $past(offset) + 2'd1));

  p_inter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p && !strobe_c && advance && interleave)
      |=> (!interleave || $countones(offset ^ $past(offset)) != 0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p && !strobe_c && !advance) |=> $stable(addr_out));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p && !strobe_c) |=> $stable(addr_out[ADDR_W-1:2]));

  always_comb begin
    if (rst_n) p_low_bits_r9: assert (addr_out[1:0] == offset);
  end
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 17;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_p = 0, strobe_c = 0, advance = 0, interleave = 0;
  logic [AW-1:0] addr_out;
  logic [1:0]    offset;

  int checks = 0;
  int failures = 0;
  int m_upper = 0, m_start = 0, m_beat = 0;
  bit done = 0;

  burst_seq #(.ADDR_W(AW)) u_burst_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p(strobe_p),
    .strobe_c(strobe_c), .advance(advance), .interleave(interleave),
    .addr_out(addr_out), .offset(offset));

  always #(PERIOD/2) clk = ~clk;

  function automatic int exp_off();
    if (interleave) return m_start ^ m_beat;
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check(string tag);
    int eo = exp_off();
    int ea = m_upper * 4 + eo;
    checks++;
    if (int'(offset) != eo || int'(addr_out) != ea || int'(addr_out[1:0]) != int'(offset)) begin
      failures++;
      $display("FAIL %s offset=%0d addr=%0h expected offset=%0d addr=%0h",
               tag, offset, addr_out, eo, ea);
    end
  endtask

  task automatic cyc(bit sp, bit sc, bit adv, int a, string tag);
    strobe_p = sp; strobe_c = sc; advance = adv; addr_in = AW'(a);
    @(posedge clk);
    if (sp || sc) begin
      m_upper = (a % (1 << AW)) / 4;
      m_start = a % 4;
      m_beat = 0;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    interleave = 0;
    cyc(1, 0, 0, 'h1ABC5, "R2");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 'h00000, "R4");
    cyc(0, 0, 0, 'h0FFFF, "R6");
    cyc(0, 0, 0, 'h12343, "R6");
    cyc(0, 0, 1, 'h00000, "R8");
    cyc(0, 0, 1, 'h00000, "R8");
    cyc(0, 1, 0, 'h0777E, "R2");
    cyc(0, 0, 1, 'h00000, "R7");
    cyc(0, 0, 1, 'h00000, "R3");
    cyc(1, 0, 1, 'h15553, "R3");
    cyc(0, 0, 1, 'h1FFFF, "R4");
    cyc(0, 1, 1, 'h0AAA2, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 'h00000, "R8");

    interleave = 1;
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 0, 'h10000 + s * 'h104 + s, "R2");
      for (int i = 0; i < 5; i++) begin
        cyc(0, 0, 1, 'h0, "R5");
        if (i == 1) cyc(0, 0, 0, 'h1234F, "R6");
      end
    end
    cyc(0, 1, 0, 'h1FFFE, "R2");
    cyc(0, 0, 1, 'h0, "R5");
    cyc(0, 1, 1, 'h00001, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 'h0, "R8");
    cyc(1, 1, 0, 'h0C0C3, "R2");
    cyc(0, 0, 1, 'h0, "R9");

    strobe_p = 0; strobe_c = 0; advance = 0;
    rst_n = 0;
    m_upper = 0; m_start = 0; m_beat = 0;
    #1;
    check("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule